// File: doc/BRIEF.md
# System Control Register Bank

This block is a bank of 32-bit system registers that answers a 4 KiB byte-address window on a single-cycle word-wide register bus. Only the lowest 512 words of the window have storage behind them. Software can write any of these words and read them back. At reset, four identification words are preloaded and every other word is cleared. Reads of three of the identification words always come back with two status bits set. Those bits are added on the read path only and are never written into storage.

One control offset sits above the backed storage. A write to it produces a one-cycle request to reset or shut down the system, and the data word selects which. Circuits outside this block act on these pulses. Any access whose word index falls beyond the backed storage is rejected and flagged on a one-cycle error strobe. This includes the control write, which therefore stores nothing.

Read data, the error strobe and both request pulses are registered. Each appears in the cycle after the clock edge that accepts the access.

Top module: `sysctl_regbank`

## Requirements
- R1: After reset, word index 0x40 (byte 0x100) holds 0x05F20121, index 0x41 (byte 0x104) holds 0x00000002, index 0x42 (byte 0x108) holds 0x05F30121 and index 0x43 (byte 0x10C) holds 0x05F40121.
- R2: After reset, every other backed word reads as zero. The backed words are byte offsets 0x000 to 0x7FC.
- R3: A write to a backed word stores all 32 data bits. A later read of that word returns them on busRdData in the cycle after the read is accepted.
- R4: A read at word index 0x40, 0x42 or 0x43 returns the stored word ORed with 0x30000000. The stored value is unchanged. A read at index 0x41 returns the stored word unmodified.
- R5: A write whose word index is 0x200 or more (byte offset 0x800 or above) is discarded. It does not alias onto any backed word.
- R6: A read whose word index is 0x200 or more returns zero.
- R7: busErr pulses for exactly one cycle after any out-of-range access. It stays low after every in-range access and whenever the bus is idle.
- R8: A write to byte offset 0xF00 with data 1 or 2 gives a one-cycle rstReq pulse in the cycle after the write.
- R9: A write to byte offset 0xF00 with data 3 gives a one-cycle offReq pulse. Any other data raises neither request, and the two requests are never high together.
- R10: A write to offset 0xF00 is also out of range: it raises busErr and stores nothing, so a later read there returns zero.
- R11: Address bits 1:0 are ignored, so an unaligned byte address reaches the word that contains it.
- R12: While reset is applied, busRdData, busErr, rstReq and offReq are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 12 | Byte address within the window |
| busWrEn | input | 1 | Write strobe, one access per cycle |
| busRdEn | input | 1 | Read strobe |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Registered read data, held between reads |
| busErr | output | 1 | One-cycle out-of-range strobe |
| rstReq | output | 1 | One-cycle system reset request |
| offReq | output | 1 | One-cycle system shutdown request |

## Verification
Reads run over the four identification words, plain cleared words and both ends of the backed range. These separate the reset preload, the status-bit forcing and the clear. Writes use dense data patterns such as 0xA5A5F00F and 0xDEADBEEF. They are placed on forced and unforced words, then read back, to show that forcing happens only on reads and that index 0x41 is left alone. Accesses at 0x800 and 0xFFC test range rejection. The 0x800 case also shows whether the index is truncated onto word 0. Control writes with data 0 to 4 separate reset, shutdown and no-request, and each is checked for pulse width.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  // Bits forced high when an identification word is read.
  localparam logic [31:0] STATUS_FORCE = 32'h3000_0000;

  // Strobes from the decoder to the storage datapath.
  typedef struct packed {
    logic wrStore;  // in-range write, store word
    logic rdStb;    // read accepted this cycle
    logic rdOor;    // read is outside backed storage
    logic rdForce;  // read of a status-forced word
  } ctlStrobe_t;

  function automatic logic [31:0] resetWord(input int unsigned idx);
    case (idx)
      32'h40:  return 32'h05F2_0121;
      32'h41:  return 32'h0000_0002;
      32'h42:  return 32'h05F3_0121;
      32'h43:  return 32'h05F4_0121;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic isForcedWord(input int unsigned idx);
    return (idx == 32'h40) || (idx == 32'h42) || (idx == 32'h43);
  endfunction

endpackage

// File: rtl/sysctl_ctrl.sv
module sysctl_ctrl
  import sysctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NUM_WORDS = 512,
  parameter logic [ADDR_W-1:0] CTRL_OFFSET = 12'hF00,
  localparam int unsigned IDX_W = $clog2(NUM_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [DATA_W-1:0] busWrData,
  output ctlStrobe_t        ctl,
  output logic [IDX_W-1:0]  wordIdx,
  output logic              busErr,
  output logic              rstReq,
  output logic              offReq
);

  localparam int unsigned WIDX_W = ADDR_W - 2;
  localparam logic [WIDX_W-1:0] LIMIT = WIDX_W'(NUM_WORDS);
  localparam logic [WIDX_W-1:0] CTRL_IDX = CTRL_OFFSET[ADDR_W-1:2];

  logic [WIDX_W-1:0] fullIdx;
  logic inRange;
  logic ctrlHit;
  logic wantReset;
  logic wantOff;

  // Bits 1:0 of the byte address are dropped here.
  assign fullIdx = busAddr[ADDR_W-1:2];
  assign inRange = fullIdx < LIMIT;
  assign wordIdx = fullIdx[IDX_W-1:0];

  always_comb begin
    ctl = '0;
    ctl.wrStore = busWrEn && inRange;
    ctl.rdStb   = busRdEn;
    ctl.rdOor   = !inRange;
    ctl.rdForce = isForcedWord(32'(fullIdx));
  end

  assign ctrlHit   = busWrEn && (fullIdx == CTRL_IDX);
  assign wantReset = ctrlHit &&
                     ((busWrData == DATA_W'(1)) || (busWrData == DATA_W'(2)));
  assign wantOff   = ctrlHit && (busWrData == DATA_W'(3));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busErr <= 1'b0;
      rstReq <= 1'b0;
      offReq <= 1'b0;
    end else begin
      busErr <= (busWrEn || busRdEn) && !inRange;
      rstReq <= wantReset;
      offReq <= wantOff;
    end
  end

  AST_RST_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |=> !rstReq); // R8
  AST_OFF_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    offReq |=> !offReq); // R9
  AST_REQ_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(rstReq && offReq)); // R9
  AST_REQ_FLAGGED: assert property (@(posedge clk) disable iff (!rstN)
    (rstReq || offReq) |-> busErr); // R10
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    busErr |-> $past(busWrEn || busRdEn)); // R7

endmodule

// File: rtl/sysctl_data.sv
module sysctl_data
  import sysctl_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NUM_WORDS = 512,
  localparam int unsigned IDX_W = $clog2(NUM_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        ctl,
  input  logic [IDX_W-1:0]  wordIdx,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);

  localparam logic [DATA_W-1:0] FORCE_BITS = DATA_W'(STATUS_FORCE);

  logic [DATA_W-1:0] words [NUM_WORDS];
  logic [DATA_W-1:0] readWord;

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        q <= DATA_W'(resetWord(i));
      end else if (ctl.wrStore && (wordIdx == IDX_W'(i))) begin
        q <= wrData;
      end
    end
    assign words[i] = q;
  end

  assign readWord = words[wordIdx] | (ctl.rdForce ? FORCE_BITS : '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (ctl.rdStb) begin
      rdData <= ctl.rdOor ? '0 : readWord;
    end
  end

  AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.rdStb && ctl.rdOor) |=> (rdData == '0)); // R6
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wrStore |=> (words[$past(wordIdx)] == $past(wrData))); // R3
  AST_RDDATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.rdStb |=> $stable(rdData)); // R3

endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
  import sysctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NUM_WORDS = 512,
  parameter logic [ADDR_W-1:0] CTRL_OFFSET = 12'hF00
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              busErr,
  output logic              rstReq,
  output logic              offReq
);

  localparam int unsigned IDX_W = $clog2(NUM_WORDS);

  ctlStrobe_t ctl;
  logic [IDX_W-1:0] wordIdx;

  sysctl_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS),
    .CTRL_OFFSET(CTRL_OFFSET)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWrData(busWrData), .ctl(ctl),
    .wordIdx(wordIdx), .busErr(busErr), .rstReq(rstReq), .offReq(offReq)
  );

  sysctl_data #(
    .DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS)
  ) i_data (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wordIdx(wordIdx),
    .wrData(busWrData), .rdData(busRdData)
  );

endmodule

// File: tb/test_sysctl_regbank.sv
module test_sysctl_regbank;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [11:0] busAddr = '0;
  logic busWrEn = 1'b0;
  logic busRdEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic busErr, rstReq, offReq;

  int nRun = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  sysctl_regbank i_sysctl_regbank (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWrData(busWrData), .busRdData(busRdData),
    .busErr(busErr), .rstReq(rstReq), .offReq(offReq)
  );

  typedef struct packed {
    logic        isWr;
    logic [11:0] addr;
    logic [31:0] data;
    logic        chkRd;
    logic [31:0] expRd;
    logic        expErr;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 12'h100, 32'h0, 1'b1, 32'h35F2_0121, 1'b0, 4'd1},   // R1 R4
    '{1'b0, 12'h104, 32'h0, 1'b1, 32'h0000_0002, 1'b0, 4'd1},   // R1, no force
    '{1'b0, 12'h108, 32'h0, 1'b1, 32'h35F3_0121, 1'b0, 4'd1},   // R1 R4
    '{1'b0, 12'h10C, 32'h0, 1'b1, 32'h35F4_0121, 1'b0, 4'd1},   // R1 R4
    '{1'b0, 12'h000, 32'h0, 1'b1, 32'h0,         1'b0, 4'd2},   // R2
    '{1'b0, 12'h7FC, 32'h0, 1'b1, 32'h0,         1'b0, 4'd2},   // R2
    '{1'b1, 12'h000, 32'hA5A5_F00F, 1'b0, 32'h0, 1'b0, 4'd7},   // R7
    '{1'b0, 12'h000, 32'h0, 1'b1, 32'hA5A5_F00F, 1'b0, 4'd3},   // R3
    '{1'b1, 12'h7FC, 32'hDEAD_BEEF, 1'b0, 32'h0, 1'b0, 4'd7},   // R7
    '{1'b0, 12'h7FC, 32'h0, 1'b1, 32'hDEAD_BEEF, 1'b0, 4'd3},   // R3
    '{1'b1, 12'h100, 32'h0, 1'b0, 32'h0,         1'b0, 4'd3},   // R3
    '{1'b0, 12'h100, 32'h0, 1'b1, 32'h3000_0000, 1'b0, 4'd4},   // R4
    '{1'b1, 12'h104, 32'h1234_5678, 1'b0, 32'h0, 1'b0, 4'd3},   // R3
    '{1'b0, 12'h104, 32'h0, 1'b1, 32'h1234_5678, 1'b0, 4'd4},   // R4
    '{1'b1, 12'h800, 32'hFFFF_FFFF, 1'b0, 32'h0, 1'b1, 4'd5},   // R5 R7
    '{1'b0, 12'h000, 32'h0, 1'b1, 32'hA5A5_F00F, 1'b0, 4'd5},   // R5 no alias
    '{1'b0, 12'h800, 32'h0, 1'b1, 32'h0,         1'b1, 4'd6},   // R6
    '{1'b0, 12'hFFC, 32'h0, 1'b1, 32'h0,         1'b1, 4'd6},   // R6
    '{1'b0, 12'h003, 32'h0, 1'b1, 32'hA5A5_F00F, 1'b0, 4'd11},  // R11
    '{1'b1, 12'h7FE, 32'h1111_2222, 1'b0, 32'h0, 1'b0, 4'd11}   // R11
  };

  task automatic check(input int req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    nRun++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL R%0d %s: got 0x%08h expected 0x%08h", req, what, got, exp);
    end
  endtask

  // Drive at falling edge, accepted at next rising edge, sampled 2 ns later.
  task automatic access(input logic wr, input logic rd,
                        input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = wr; busRdEn = rd; busAddr = a; busWrData = d;
    @(posedge clk);
    #2;
    @(negedge clk);
    busWrEn = 1'b0; busRdEn = 1'b0;
  endtask

  task automatic ctrlWrite(input logic [31:0] d, input logic expR,
                           input logic expO);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = 12'hF00; busWrData = d;
    @(posedge clk);
    #2;
    check(8, "rstReq after control write", 32'(rstReq), 32'(expR));
    check(9, "offReq after control write", 32'(offReq), 32'(expO));
    check(10, "busErr on control write", 32'(busErr), 32'd1);
    @(negedge clk);
    busWrEn = 1'b0;
    @(posedge clk);
    #2;
    check(8, "rstReq width one cycle", 32'(rstReq), 32'd0);
    check(9, "offReq width one cycle", 32'(offReq), 32'd0);
    check(7, "busErr width one cycle", 32'(busErr), 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nRun++; nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    // R12: outputs during reset
    repeat (3) @(posedge clk);
    #2;
    check(12, "busRdData in reset", busRdData, 32'h0);
    check(12, "flags in reset", {29'd0, busErr, rstReq, offReq}, 32'h0);
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      busWrEn = VECS[i].isWr; busRdEn = !VECS[i].isWr;
      busAddr = VECS[i].addr; busWrData = VECS[i].data;
      @(posedge clk);
      #2;
      if (VECS[i].chkRd)
        check(int'(VECS[i].req), $sformatf("vector %0d read", i), busRdData, VECS[i].expRd);
      check(VECS[i].expErr ? 7 : int'(VECS[i].req),
            $sformatf("vector %0d busErr", i), 32'(busErr), 32'(VECS[i].expErr));
      @(negedge clk);
      busWrEn = 1'b0; busRdEn = 1'b0;
    end

    // R11: the unaligned write at 0x7FE landed in word 0x1FF
    access(1'b0, 1'b1, 12'h7FC, 32'h0);
    check(11, "unaligned write landed", busRdData, 32'h1111_2222);

    // R7: idle bus keeps busErr low
    @(posedge clk); #2;
    check(7, "busErr idle", 32'(busErr), 32'd0);

    // R8 R9 R10: control writes
    ctrlWrite(32'd1, 1'b1, 1'b0);
    ctrlWrite(32'd2, 1'b1, 1'b0);
    ctrlWrite(32'd3, 1'b0, 1'b1);
    ctrlWrite(32'd0, 1'b0, 1'b0);
    ctrlWrite(32'd4, 1'b0, 1'b0);
    access(1'b0, 1'b1, 12'hF00, 32'h0);
    check(10, "control offset stores nothing", busRdData, 32'h0);
    access(1'b0, 1'b1, 12'h000, 32'h0);
    check(10, "control write did not alias word 0", busRdData, 32'hA5A5_F00F);

    // R1 R2: reset again restores preload and clears written words
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    access(1'b0, 1'b1, 12'h000, 32'h0);
    check(2, "word 0 cleared by reset", busRdData, 32'h0);
    access(1'b0, 1'b1, 12'h104, 32'h0);
    check(1, "word 0x41 reloaded", busRdData, 32'h0000_0002);
    access(1'b0, 1'b1, 12'h100, 32'h0);
    check(1, "word 0x40 reloaded", busRdData, 32'h35F2_0121);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule